// File: doc/BRIEF.md
# Dual-Alias Register Window Decoder

This block sits between the processor's physical address path and a bank of internal control registers. It looks at each address and decides whether the address falls in a 64 KB register window. Two windows are checked at once. One has a base that never changes. The other has its base in a programmable base register, so software can move it. Both windows lead to the same register space. A hit in either one gives the same 16-bit register offset, so the same offset reaches the same register through either alias.

Only full-word accesses are legal. An access that hits a window but does not enable all four byte lanes is flagged as an error and writes nothing. The block also flags any address inside the uncached region 0xFF00_0000 to 0xFF3F_FFFF, whether or not it hits a window. The programmable base register is mapped inside the window itself, so software reads and writes it through either alias.

Responses are registered. A small state machine has two states. ST_IDLE means no response is presented. ST_RESP means the registered decode of the previous cycle's request is on the outputs. The machine has these transitions:
- ST_IDLE to ST_RESP when the request strobe is high.
- ST_RESP to ST_RESP when a new request arrives back to back.
- ST_RESP to ST_IDLE when no request arrives.
- Any state to ST_IDLE on synchronous reset.

Top module: `regwin_decoder`

## Requirements
- R1: After synchronous active-high reset, every response output is 0 and base_o reads 0xFF1F_0000.
- R2: A request whose address bits [31:16] equal 0xFF1F gives hit_o=1 and offset_o equal to address bits [15:0]. These appear in the cycle after the strobe.
- R3: A request whose address bits [31:16] equal bits [31:16] of the programmable base gives hit_o=1 and offset_o equal to address bits [15:0].
- R4: When the programmable base equals 0xFF1F_0000, an address in that shared window gives one ordinary hit: hit_o=1, the plain offset, and no error.
- R5: A request that hits neither window gives hit_o=0, offset_o=0, err_o=0 and rdata_o=0.
- R6: A hit whose byte enables req_be are not all four ones (4'hF) gives err_o=1 with hit_o=1. Such an access leaves the base register unchanged.
- R7: uncached_o is 1 exactly when the request address lies in 0xFF00_0000..0xFF3F_FFFF inclusive. This holds whether or not the address hits a window.
- R8: A full-word write that hits either window at offset 0x0010 loads req_wdata[31:16] into the base register. The low 16 bits of the base always read as 0. The new base shows on base_o and is used for decoding from the next cycle on.
- R9: A full-word read that hits either window at offset 0x0010 returns {base[31:16],16'h0000} on rdata_o. Every other response returns rdata_o=0.
- R10: resp_valid_o is 1 exactly in the cycle after a cycle with req_valid=1. In all other cycles, hit_o, offset_o, err_o, uncached_o and rdata_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address-valid strobe, one request per cycle |
| req_addr | input | 32 | Physical address |
| req_be | input | 4 | Byte-lane enables; 4'hF is a full word |
| req_wr | input | 1 | Write strobe |
| req_rd | input | 1 | Read strobe |
| req_wdata | input | 32 | Write data |
| resp_valid_o | output | 1 | Response present (state ST_RESP) |
| hit_o | output | 1 | Address hit one of the two windows |
| offset_o | output | 16 | Register offset inside the window |
| err_o | output | 1 | Hit with an illegal access size |
| uncached_o | output | 1 | Address is in the uncached region |
| rdata_o | output | 32 | Read data of the base register |
| base_o | output | 32 | Current programmable base |

## Verification
Each decode result is due exactly one clock after the edge that samples the strobe. The bench drives a request at a falling edge and reads hit, offset, error, uncached flag and read data at the next falling edge, halfway through the response cycle. A base-register write changes base_o at that same edge. The bench updates its model base only after it has computed the expected values for the current request, so the following request is predicted with the new base. Between requests there is one idle cycle, and the bench checks that it presents all zeros.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } regwin_state_e;

    function automatic logic in_range(input logic [31:0] a,
                                      input logic [31:0] lo,
                                      input logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/regwin_match.sv
module regwin_match #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16,
    localparam int BASE_W = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] win_base,
    output logic              match
);
    assign match = (addr[ADDR_W-1:OFS_W] == win_base);
endmodule

// File: rtl/regwin_basereg.sv
module regwin_basereg #(
    parameter int              ADDR_W     = 32,
    parameter int              OFS_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_RESET = 32'hFF1F_0000,
    localparam int             BASE_W     = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] wdata,
    output logic [BASE_W-1:0] base_q,
    output logic [ADDR_W-1:0] base_full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= BASE_RESET[ADDR_W-1:OFS_W];
        end else if (we) begin
            base_q <= wdata[ADDR_W-1:OFS_W];
        end
    end

    assign base_full = {base_q, {OFS_W{1'b0}}};
endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
    import regwin_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter int                OFS_W        = 16,
    parameter logic [ADDR_W-1:0] FIXED_BASE   = 32'hFF1F_0000,
    parameter logic [ADDR_W-1:0] BASE_RESET   = 32'hFF1F_0000,
    parameter logic [OFS_W-1:0]  BASE_REG_OFS = 16'h0010,
    parameter logic [ADDR_W-1:0] UC_LO        = 32'hFF00_0000,
    parameter logic [ADDR_W-1:0] UC_HI        = 32'hFF3F_FFFF,
    localparam int               BE_W         = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic              req_wr,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_wdata,
    output logic              resp_valid_o,
    output logic              hit_o,
    output logic [OFS_W-1:0]  offset_o,
    output logic              err_o,
    output logic              uncached_o,
    output logic [ADDR_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] base_o
);
    localparam int BASE_W = ADDR_W - OFS_W;
    localparam int NWIN   = 2;

    logic [BASE_W-1:0] base_q;
    logic [ADDR_W-1:0] base_full;
    logic [BASE_W-1:0] win_base [NWIN];
    logic [NWIN-1:0]   win_match;

    logic              any_hit;
    logic              full_word;
    logic              at_base;
    logic              base_we;
    logic              in_uc;
    logic [OFS_W-1:0]  req_ofs;

    regwin_state_e     state, nxt;

    logic              cap_hit;
    logic [OFS_W-1:0]  cap_ofs;
    logic              cap_err;
    logic              cap_uc;
    logic [ADDR_W-1:0] cap_rdata;

    // Window 0 is fixed, window 1 follows the programmable base.
    assign win_base[0] = FIXED_BASE[ADDR_W-1:OFS_W];
    assign win_base[1] = base_q;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        regwin_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_match (
            .addr     (req_addr),
            .win_base (win_base[w]),
            .match    (win_match[w])
        );
    end

    // Both aliases collapse onto a single hit and one offset.
    assign any_hit   = |win_match;
    assign full_word = &req_be;
    assign req_ofs   = req_addr[OFS_W-1:0];
    assign at_base   = any_hit && full_word && (req_ofs == BASE_REG_OFS);
    assign base_we   = req_valid && req_wr && at_base;
    assign in_uc     = in_range(req_addr, UC_LO, UC_HI);

    regwin_basereg #(
        .ADDR_W     (ADDR_W),
        .OFS_W      (OFS_W),
        .BASE_RESET (BASE_RESET)
    ) i_basereg (
        .clk       (clk),
        .rst       (rst),
        .we        (base_we),
        .wdata     (req_wdata),
        .base_q    (base_q),
        .base_full (base_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) nxt = ST_RESP;
            ST_RESP: nxt = req_valid ? ST_RESP : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_hit   <= 1'b0;
            cap_ofs   <= '0;
            cap_err   <= 1'b0;
            cap_uc    <= 1'b0;
            cap_rdata <= '0;
        end else if (req_valid) begin
            cap_hit   <= any_hit;
            cap_ofs   <= any_hit ? req_ofs : '0;
            cap_err   <= any_hit && !full_word;
            cap_uc    <= in_uc;
            cap_rdata <= (req_rd && at_base) ? base_full : '0;
        end
    end

    always_comb begin
        resp_valid_o = 1'b0;
        hit_o        = 1'b0;
        offset_o     = '0;
        err_o        = 1'b0;
        uncached_o   = 1'b0;
        rdata_o      = '0;
        unique case (state)
            ST_IDLE: ;
            ST_RESP: begin
                resp_valid_o = 1'b1;
                hit_o        = cap_hit;
                offset_o     = cap_ofs;
                err_o        = cap_err;
                uncached_o   = cap_uc;
                rdata_o      = cap_rdata;
            end
            default: ;
        endcase
    end

    assign base_o = base_full;
endmodule

// File: rtl/regwin_checker.sv
module regwin_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        req_wr,
    input logic        resp_valid_o,
    input logic        hit_o,
    input logic [15:0] offset_o,
    input logic        err_o,
    input logic        uncached_o,
    input logic [31:0] base_o
);
    p_resp_after_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid_o);
    p_no_resp_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!resp_valid_o && !hit_o && !err_o && !uncached_o));
    p_miss_zero_ofs_r5: assert property (@(posedge clk) disable iff (rst)
        !hit_o |-> (offset_o == 16'h0));
    p_err_needs_hit_r6: assert property (@(posedge clk) disable iff (rst)
        err_o |-> hit_o);
    p_fixed_hit_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[31:16] == 16'hFF1F)
        |=> (hit_o && offset_o == $past(req_addr[15:0])));
    p_uncached_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[31:22] == 10'h3FC) |=> uncached_o);
    p_base_low_zero_r8: assert property (@(posedge clk) disable iff (rst)
        base_o[15:0] == 16'h0);
    p_base_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_wr) |=> $stable(base_o));
endmodule

bind regwin_decoder regwin_checker i_regwin_checker (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_wr       (req_wr),
    .resp_valid_o (resp_valid_o),
    .hit_o        (hit_o),
    .offset_o     (offset_o),
    .err_o        (err_o),
    .uncached_o   (uncached_o),
    .base_o       (base_o)
);

// File: tb/test_regwin_decoder.sv
module test_regwin_decoder;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [3:0]  req_be;
    logic        req_wr;
    logic        req_rd;
    logic [31:0] req_wdata;
    logic        resp_valid_o, hit_o, err_o, uncached_o;
    logic [15:0] offset_o;
    logic [31:0] rdata_o, base_o;

    int checks = 0;
    int fails  = 0;
    logic [15:0] mbase;

    always #4 clk = ~clk;

    regwin_decoder i_regwin_decoder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_be(req_be), .req_wr(req_wr), .req_rd(req_rd), .req_wdata(req_wdata),
        .resp_valid_o(resp_valid_o), .hit_o(hit_o), .offset_o(offset_o),
        .err_o(err_o), .uncached_o(uncached_o), .rdata_o(rdata_o), .base_o(base_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic exp_hit(input logic [31:0] a);
        return (a[31:16] == 16'hFF1F) || (a[31:16] == mbase);
    endfunction

    function automatic logic exp_uc(input logic [31:0] a);
        return (a >= 32'hFF00_0000) && (a <= 32'hFF3F_FFFF);
    endfunction

    task automatic txn(input logic [31:0] a, input logic [3:0] be,
                       input logic wr, input logic [31:0] wd, input string tag);
        logic h, full, atb;
        logic [31:0] erd;
        h    = exp_hit(a);
        full = (be == 4'hF);
        atb  = h && full && (a[15:0] == 16'h0010);
        erd  = (!wr && atb) ? {mbase, 16'h0} : 32'h0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_be = be;
        req_wr = wr; req_rd = !wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr && atb) mbase = wd[31:16];
        chk({tag, " R10 resp_valid"}, {31'h0, resp_valid_o}, 32'h1);
        chk({tag, " R2/R3 hit"},      {31'h0, hit_o}, {31'h0, h});
        chk({tag, " R5 offset"},      {16'h0, offset_o}, h ? {16'h0, a[15:0]} : 32'h0);
        chk({tag, " R6 err"},         {31'h0, err_o}, {31'h0, h && !full});
        chk({tag, " R7 uncached"},    {31'h0, uncached_o}, {31'h0, exp_uc(a)});
        chk({tag, " R9 rdata"},       rdata_o, erd);
        chk({tag, " R8 base"},        base_o, {mbase, 16'h0});
        @(negedge clk);
        chk({tag, " R10 idle"}, {resp_valid_o, hit_o, err_o, uncached_o, offset_o, 12'h0},
            32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4925));
        mbase = 16'hFF1F;
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_be = '0;
        req_wr = 1'b0; req_rd = 1'b0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 resp", {resp_valid_o, hit_o, err_o, uncached_o}, 32'h0);
        chk("R1 rdata", rdata_o, 32'h0);
        chk("R1 base", base_o, 32'hFF1F_0000);
        // R4 both windows coincide
        txn(32'hFF1F_1234, 4'hF, 1'b0, 32'h0, "R4 shared");
        // R9 read base via fixed alias
        txn(32'hFF1F_0010, 4'hF, 1'b0, 32'h0, "R9 read");
        // R8 relocate, low bits ignored
        txn(32'hFF1F_0010, 4'hF, 1'b1, 32'h1234_ABCD, "R8 write");
        chk("R8 base value", base_o, 32'h1234_0000);
        // R3 relocated alias
        txn(32'h1234_0040, 4'hF, 1'b0, 32'h0, "R3 reloc");
        txn(32'h1234_0010, 4'hF, 1'b0, 32'h0, "R9 reloc read");
        // R2 fixed alias still live
        txn(32'hFF1F_0040, 4'hF, 1'b0, 32'h0, "R2 fixed");
        // R6 partial write ignored
        txn(32'hFF1F_0010, 4'h3, 1'b1, 32'h5555_0000, "R6 partial");
        chk("R6 base kept", base_o, 32'h1234_0000);
        // R5 miss, R7 range edges
        txn(32'h0000_1000, 4'hF, 1'b0, 32'h0, "R5 miss");
        txn(32'hFF00_0000, 4'hF, 1'b0, 32'h0, "R7 low edge");
        txn(32'hFF3F_FFFF, 4'hF, 1'b0, 32'h0, "R7 high edge");
        txn(32'hFF40_0000, 4'hF, 1'b0, 32'h0, "R7 above");
        txn(32'hFEFF_FFFF, 4'hF, 1'b0, 32'h0, "R7 below");
        // restore base through relocated alias
        txn(32'h1234_0010, 4'hF, 1'b1, 32'hFF1F_0000, "R8 restore");
        chk("R8 restored", base_o, 32'hFF1F_0000);
        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic [3:0]  be;
            logic        wr;
            logic [31:0] wd;
            int sel;
            sel = $urandom_range(0, 3);
            case (sel)
                0: a = {16'hFF1F, 16'($urandom_range(0, 3) == 0 ? 16'h0010 : 16'($urandom()))};
                1: a = {mbase, 16'($urandom_range(0, 3) == 0 ? 16'h0010 : 16'($urandom()))};
                2: a = {10'h3FC, 22'($urandom())};
                default: a = $urandom();
            endcase
            be = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'hF;
            wr = 1'($urandom());
            wd = {($urandom_range(0, 1) == 0) ? 16'hFF1F : 16'($urandom()), 16'($urandom())};
            txn(a, be, wr, wd, "rand");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule